// File: doc/BRIEF.md
# System Control Register Block

A small memory-mapped control peripheral that sits on a plain synchronous register bus. It gives software three services: a write-only strobe that asks the processor to sleep until an interrupt, a read-only identification word, and a reset status word that tells software whether the last reset came from power-up.

Software never writes the status word directly. It changes it by writing a bit mask to one of two separate locations. Ones in a mask written to the clear location drop the matching flags. Ones in a mask written to the set location raise the matching flags. Zeros in either mask leave flags alone. Bit 0 is the power-on flag, which only a real power-on reset can raise. A warm reset returns the sleep request to idle and leaves every status flag as it was.

Register map (byte offsets): 0x00 pause (write only), 0x04 identification (read only), 0x08 reset status (read only), 0x0C status clear (write only), 0x10 status set (write only). Read data is combinational and valid in the same cycle as the read enable.

Top module: `sysctl_regblock`

## Requirements
- R1: After a power-on reset, pauseReq is 0, the reset status word at 0x08 reads 0x00000001, and all of its other bits are 0.
- R2: A write to 0x00 with any data while irq is low makes pauseReq 1 after that clock edge, and it stays 1 while irq stays low.
- R3: pauseReq is 0 after any clock edge at which irq is 1. A write to 0x00 at an edge where irq is 1 leaves pauseReq at 0.
- R4: A read of 0x04 returns {ID_INFO, b0}, where b0 is 1 if ID_INFO is nonzero and 0 otherwise. A write to 0x04 changes nothing.
- R5: A write to 0x0C clears each status bit whose data bit is 1, bit 0 included, and leaves bits whose data bit is 0 unchanged.
- R6: A write to 0x10 sets each status bit above bit 0 whose data bit is 1 and leaves the other bits unchanged. It never sets bit 0.
- R7: A warm reset clears pauseReq and leaves every reset status bit unchanged.
- R8: A read of 0x00, 0x0C, 0x10 or any unmapped address returns 0. A write to 0x08 or to an unmapped address changes no state.
- R9: rdData is 0 in any cycle in which rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| warmRstN | input | 1 | Warm reset, active low, asynchronous |
| addr | input | ADDR_W (8) | Byte address of the access |
| wrEn | input | 1 | Write enable, one access per cycle |
| rdEn | input | 1 | Read enable |
| wrData | input | DATA_W (32) | Write data or bit mask |
| rdData | output | DATA_W (32) | Combinational read data |
| irq | input | 1 | Interrupt that ends the sleep request |
| pauseReq | output | 1 | Wait-for-interrupt request to the processor |

## Verification
On every cycle, the assertions check the edge relations of the sleep request: a pause write with no interrupt raises it, and an interrupt drops it. They also check that a clear mask drops the power-on flag, that a set mask cannot raise it, and that reads of write-only or unmapped locations return zero. Only the bench's scenarios can show the cases that need history across many cycles. These are that a warm reset keeps the status flags, that set and clear masks combined over long random sequences leave exactly the expected word, that writes to read-only and unmapped locations leave state unchanged, and that the identification value follows the parameter.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Byte offsets of the register locations; decode depends on these values.
  localparam int OFF_PAUSE = 'h00;
  localparam int OFF_IDENT = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_CLR   = 'h0C;
  localparam int OFF_SET   = 'h10;

  // Per-cycle strobes from the decoder to the datapath.
  typedef struct packed {
    logic pauseWr;
    logic clrWr;
    logic setWr;
    logic identRd;
    logic statRd;
  } regStrobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb         = '0;
    strb.pauseWr = wrEn && hit(addr, OFF_PAUSE);
    strb.clrWr   = wrEn && hit(addr, OFF_CLR);
    strb.setWr   = wrEn && hit(addr, OFF_SET);
    strb.identRd = rdEn && hit(addr, OFF_IDENT);
    strb.statRd  = rdEn && hit(addr, OFF_STAT);
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter logic [DATA_W-2:0] ID_INFO = '0
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irq,
  output logic [DATA_W-1:0] rdData,
  output logic              pauseReq
);

  localparam logic              ID_MORE = (ID_INFO != '0);
  localparam logic [DATA_W-1:0] ID_WORD = {ID_INFO, ID_MORE};

  logic              pauseQ;
  logic              porFlagQ;
  logic [DATA_W-1:0] statusQ;

  // Sleep request: interrupt wins over a same-cycle pause write.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          pauseQ <= 1'b0;
    else if (irq)          pauseQ <= 1'b0;
    else if (strb.pauseWr) pauseQ <= 1'b1;
  end

  // Power-on flag: raised only by power-on reset, dropped only by a clear mask.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                     porFlagQ <= 1'b1;
    else if (strb.clrWr && wrData[0]) porFlagQ <= 1'b0;
  end

  assign statusQ[0] = porFlagQ;

  // Software-owned flags above bit 0; only power-on reset touches them.
  for (genvar b = 1; b < DATA_W; b++) begin : g_flag
    logic flagQ;
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN)                     flagQ <= 1'b0;
      else if (strb.clrWr && wrData[b]) flagQ <= 1'b0;
      else if (strb.setWr && wrData[b]) flagQ <= 1'b1;
    end
    assign statusQ[b] = flagQ;
  end

  always_comb begin
    rdData = '0;
    if (strb.identRd)     rdData = ID_WORD;
    else if (strb.statRd) rdData = statusQ;
  end

  assign pauseReq = pauseQ;

  // R3
  irq_drops_pause_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    irq |=> !pauseReq);

  // R2
  pause_raise_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (strb.pauseWr && !irq) |=> pauseReq);

  // R5
  por_flag_clear_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.clrWr && wrData[0]) |=> !statusQ[0]);

  // R6
  por_flag_noset_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.setWr && !statusQ[0]) |=> !statusQ[0]);

endmodule

// File: rtl/sysctl_regblock.sv
module sysctl_regblock
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-2:0] ID_INFO = (DATA_W-1)'('h5A3)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              irq,
  output logic              pauseReq
);

  regStrobe_t strb;
  logic       sysRstN;

  assign sysRstN = porRstN & warmRstN;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  sysctl_datapath #(.DATA_W(DATA_W), .ID_INFO(ID_INFO)) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .strb     (strb),
    .wrData   (wrData),
    .irq      (irq),
    .rdData   (rdData),
    .pauseReq (pauseReq)
  );

  // R8
  quiet_read_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (rdEn && !strb.identRd && !strb.statRd) |-> (rdData == '0));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !rdEn |-> (rdData == '0));

endmodule

// File: tb/sim_sysctl_regblock.sv
`timescale 1ns/1ps
module sim_sysctl_regblock;

  localparam logic [30:0] IDV = 31'h5A3;
  localparam logic [31:0] ID_EXP = {IDV, 1'b1};

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        warmRstN = 1'b1;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq = 1'b0;
  logic        pauseReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] statM;
  logic        pauseM;

  always #4 clk = ~clk;

  sysctl_regblock #(.ADDR_W(8), .DATA_W(32), .ID_INFO(IDV)) u0 (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .irq(irq), .pauseReq(pauseReq)
  );

  function automatic logic [31:0] readExp(input logic [7:0] a, input logic [31:0] s);
    if (a == 8'h04) return ID_EXP;
    if (a == 8'h08) return s;
    return 32'h0;
  endfunction

  function automatic logic [31:0] nextStat(input logic [7:0] a, input logic [31:0] d,
                                           input bit w, input logic [31:0] s);
    if (!w) return s;
    if (a == 8'h0C) return s & ~d;
    if (a == 8'h10) return s | (d & 32'hFFFF_FFFE);
    return s;
  endfunction

  function automatic logic nextPause(input logic [7:0] a, input bit w, input bit i,
                                     input logic p);
    if (i) return 1'b0;
    if (w && a == 8'h00) return 1'b1;
    return p;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [31:0] d, input bit w,
                      input bit r, input bit i, input string tag);
    @(negedge clk);
    addr = a; wrData = d; wrEn = w; rdEn = r; irq = i;
    #1;
    if (r) check(rdData, readExp(a, statM), tag);
    else   check(rdData, 32'h0, "R9 idle read");
    @(posedge clk);
    statM  = nextStat(a, d, w, statM);
    pauseM = nextPause(a, w, i, pauseM);
    #1;
    check({31'h0, pauseReq}, {31'h0, pauseM}, tag);
    wrEn = 1'b0; rdEn = 1'b0; irq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    statM = 32'h1; pauseM = 1'b0;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    #1;
    // R1 reset state
    check({31'h0, pauseReq}, 32'h0, "R1 pause after por");
    step(8'h08, 0, 0, 1, 0, "R1 status after por");
    // R4 identification, and write to it ignored
    step(8'h04, 0, 0, 1, 0, "R4 ident read");
    step(8'h04, 32'hFFFF_FFFF, 1, 0, 0, "R4 ident write");
    step(8'h04, 0, 0, 1, 0, "R4 ident after write");
    // R6 set cannot raise bit 0 once cleared; R5 clear
    step(8'h0C, 32'h1, 1, 0, 0, "R5 clear por flag");
    step(8'h08, 0, 0, 1, 0, "R5 status after clear");
    step(8'h10, 32'hFFFF_FFFF, 1, 0, 0, "R6 set all");
    step(8'h08, 0, 0, 1, 0, "R6 status after set");
    step(8'h0C, 32'h0000_F0F0, 1, 0, 0, "R5 partial clear");
    step(8'h08, 0, 0, 1, 0, "R5 status after partial clear");
    // R8 writes to read-only and unmapped locations ignored; reads return 0
    step(8'h08, 32'h0, 1, 0, 0, "R8 write to status");
    step(8'h44, 32'hFFFF_FFFF, 1, 0, 0, "R8 unmapped write");
    step(8'h08, 0, 0, 1, 0, "R8 status unchanged");
    step(8'h00, 0, 0, 1, 0, "R8 read pause loc");
    step(8'h0C, 0, 0, 1, 0, "R8 read clear loc");
    step(8'h10, 0, 0, 1, 0, "R8 read set loc");
    step(8'h09, 0, 0, 1, 0, "R8 unaligned read");
    // R2 pause with zero data, held; R3 irq clears; write with irq blocked
    step(8'h00, 32'h0, 1, 0, 0, "R2 pause write");
    step(8'h04, 0, 0, 0, 0, "R2 pause held");
    step(8'h00, 0, 0, 0, 1, "R3 irq clears");
    step(8'h00, 32'h5, 1, 0, 1, "R3 write during irq");
    // R7 warm reset keeps status, clears pause
    step(8'h00, 32'h1, 1, 0, 0, "R7 pause before warm");
    @(negedge clk); warmRstN = 1'b0;
    @(negedge clk); warmRstN = 1'b1;
    pauseM = 1'b0;
    #1;
    check({31'h0, pauseReq}, 32'h0, "R7 pause after warm");
    step(8'h08, 0, 0, 1, 0, "R7 status kept over warm");
    // R1 power-on reset again restores flag and clears others
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    statM = 32'h1; pauseM = 1'b0;
    step(8'h08, 0, 0, 1, 0, "R1 status after second por");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08;
        3: a = 8'h0C; 4: a = 8'h10; 5: a = 8'h0C;
        default: a = 8'($urandom);
      endcase
      step(a, $urandom, ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 3) == 0), "R5 R6 R2 R3 random");
      step(8'h08, 0, 0, 1, 0, "R5 R6 random status");
    end
    finishRun();
  end

endmodule